// File: doc/BRIEF.md
# Coincidence-Terminated Delay and Width Timer

This block turns a trigger into a delayed output pulse. It has two timing stages in series. The delay stage starts on an accepted trigger and counts a programmed number of clocks. When its count ends, it starts the width stage, which holds the output pulse high for its own programmed number of clocks. Each stage uses a split down-counter: a fast low section that decrements every running clock, and a slow high section that moves only when the low section borrows. A stage ends in the cycle where both sections read zero together. The clock edge that ends the stage also reloads the programmed value into the counter.

The control side programs the two counts. While it is writing them, it raises a loading flag, and no trigger is accepted during that time. A trigger that arrives while a delay cycle is running is dropped. It also sets a sticky overlap flag, which the control side reads and later clears with a clear pulse. In double-pulse mode, the width stage also fires at the start of the delay, so one trigger can produce two output pulses.

Top module: `pulse_delay_timer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, trigOut, pulseOut, overlapFlag and busy are all 0.
- R2: A one-cycle trigIn that arrives while the block is idle and loadBusy is 0 makes trigOut high for exactly one cycle, the cycle after the trigger. busy rises in that same cycle.
- R3: For a programmed delay D, with D = high*2^LO_W + low, the delay stage stays active for D+1 cycles, counting from the cycle after the trigger. The low section counts down to zero, then wraps to all ones and borrows one from the high section.
- R4: pulseOut rises in the cycle after the delay stage ends and stays high for W+1 cycles for a programmed width W. busy is high from the trigOut cycle to the last pulseOut cycle.
- R5: A count of zero in either stage gives a one-cycle stage. The stage never runs an unbounded count.
- R6: A trigger that arrives while loadBusy is 1 is refused: no trigOut, no pulseOut, busy stays 0 and no overlap is recorded.
- R7: A trigger that arrives while the delay stage is active leaves the running timing unchanged and sets overlapFlag.
- R8: overlapFlag stays set until ovlClr is pulsed. If an overlapping trigger and ovlClr arrive in the same cycle, the flag stays set.
- R9: With doubleMode = 1, pulseOut is also high for W+1 cycles starting with the trigOut cycle. The delay-end pulse then follows as in R4, but only if the width stage is idle at delay end (D > W). Otherwise that second start is ignored.
- R10: Counts are captured only while a stage is idle. A change of delayCount during a running cycle affects only the next trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigIn | input | 1 | Trigger request, one cycle per trigger |
| loadBusy | input | 1 | Control side is loading counts; triggers are refused |
| doubleMode | input | 1 | Also start the width stage at delay start |
| ovlClr | input | 1 | Clears the sticky overlap flag |
| delayCount | input | LO_W+HI_W | Programmed delay count D |
| widthCount | input | LO_W+HI_W | Programmed width count W |
| trigOut | output | 1 | One-cycle pulse at the start of the delay |
| pulseOut | output | 1 | Output pulse, high while the width stage runs |
| overlapFlag | output | 1 | Sticky record of a trigger that arrived too early |
| busy | output | 1 | Either stage active |

## Verification
Two events can arrive in one cycle: an overlapping trigger that sets the overlap flag, and a clear pulse for that flag. The bench drives trigIn and ovlClr together in the middle of a running delay and expects the flag to read 1 afterwards. It then expects a later lone clear to bring the flag to 0. Double-pulse mode gives a second collision: the delay stage can end while the width stage is still busy. Runs with D > W and D < W check whether the second pulse is issued or suppressed, comparing the pulseOut trace cycle by cycle against a trace computed from D and W.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
  localparam int NUM_STAGES = 2;
  localparam int STG_DELAY  = 0;
  localparam int STG_WIDTH  = 1;

  // Strobes from control to datapath, one bit per stage
  typedef struct packed {
    logic [NUM_STAGES-1:0] run;     // decrement this clock
    logic [NUM_STAGES-1:0] reload;  // load programmed count this clock
  } pdtStrobe_t;
endpackage

// File: rtl/pdt_split_counter.sv
module pdt_split_counter #(
  parameter int LO_W = 4,
  parameter int HI_W = 4,
  localparam int CNT_W = LO_W + HI_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] loadVal,
  input  logic             run,
  input  logic             reload,
  output logic             coinc
);
  logic [LO_W-1:0] loCnt;
  logic [HI_W-1:0] hiCnt;
  logic loZero, hiZero, loBorrow;

  assign loZero   = (loCnt == '0);
  assign hiZero   = (hiCnt == '0);
  assign loBorrow = run && loZero;   // carry of fast section enables slow section
  assign coinc    = loZero && hiZero;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loCnt <= '0;
      hiCnt <= '0;
    end else if (reload) begin
      loCnt <= loadVal[LO_W-1:0];
      hiCnt <= loadVal[CNT_W-1:LO_W];
    end else if (run) begin
      loCnt <= loCnt - 1'b1;
      if (loBorrow) hiCnt <= hiCnt - 1'b1;
    end
  end

  // R3
  lo_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (run && !reload && loZero && !hiZero) |=>
      (loCnt == {LO_W{1'b1}} && hiCnt == $past(hiCnt) - HI_W'(1)));

  // R3
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (run && !reload && !loZero) |=> $stable(hiCnt));
endmodule

// File: rtl/pdt_datapath.sv
module pdt_datapath
  import pdt_pkg::*;
#(
  parameter int LO_W = 4,
  parameter int HI_W = 4,
  localparam int CNT_W = LO_W + HI_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [CNT_W-1:0]      delayCount,
  input  logic [CNT_W-1:0]      widthCount,
  input  pdtStrobe_t            strobe,
  output logic [NUM_STAGES-1:0] coinc
);
  logic [NUM_STAGES-1:0][CNT_W-1:0] loadVals;

  assign loadVals[STG_DELAY] = delayCount;
  assign loadVals[STG_WIDTH] = widthCount;

  for (genvar gi = 0; gi < NUM_STAGES; gi++) begin : g_stage
    pdt_split_counter #(.LO_W(LO_W), .HI_W(HI_W)) u_cnt (
      .clk     (clk),
      .rstN    (rstN),
      .loadVal (loadVals[gi]),
      .run     (strobe.run[gi]),
      .reload  (strobe.reload[gi]),
      .coinc   (coinc[gi])
    );
  end
endmodule

// File: rtl/pdt_control.sv
module pdt_control
  import pdt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  trigIn,
  input  logic                  loadBusy,
  input  logic                  doubleMode,
  input  logic                  ovlClr,
  input  logic [NUM_STAGES-1:0] coinc,
  output pdtStrobe_t            strobe,
  output logic                  trigOut,
  output logic                  pulseOut,
  output logic                  overlapFlag,
  output logic                  busy
);
  logic delayActive, widthActive;
  logic delayAccept, delayEnd, widthTrig, widthAccept, widthEnd;

  assign delayAccept = trigIn && !loadBusy && !delayActive;
  assign delayEnd    = delayActive && coinc[STG_DELAY];
  assign widthTrig   = delayEnd || (doubleMode && delayAccept);
  assign widthAccept = widthTrig && !loadBusy && !widthActive;
  assign widthEnd    = widthActive && coinc[STG_WIDTH];

  always_comb begin
    strobe.run[STG_DELAY]    = delayActive && !coinc[STG_DELAY];
    strobe.reload[STG_DELAY] = !delayActive || delayEnd;
    strobe.run[STG_WIDTH]    = widthActive && !coinc[STG_WIDTH];
    strobe.reload[STG_WIDTH] = !widthActive || widthEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      delayActive <= 1'b0;
      widthActive <= 1'b0;
      trigOut     <= 1'b0;
      overlapFlag <= 1'b0;
    end else begin
      if (delayAccept)   delayActive <= 1'b1;
      else if (delayEnd) delayActive <= 1'b0;
      if (widthAccept)   widthActive <= 1'b1;
      else if (widthEnd) widthActive <= 1'b0;
      trigOut <= delayAccept;
      if (trigIn && delayActive) overlapFlag <= 1'b1;
      else if (ovlClr)           overlapFlag <= 1'b0;
    end
  end

  assign pulseOut = widthActive;
  assign busy     = delayActive || widthActive;

  // R2
  trigout_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |=> !trigOut);

  // R2
  trigout_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |-> $past(trigIn && !loadBusy));

  // R3
  delay_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(delayActive) |-> $past(coinc[STG_DELAY]));

  // R4
  width_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pulseOut) |-> $past(coinc[STG_WIDTH]));

  // R6
  load_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(delayActive) |-> $past(!loadBusy));

  // R8
  overlap_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overlapFlag && !ovlClr) |=> overlapFlag);
endmodule

// File: rtl/pulse_delay_timer.sv
module pulse_delay_timer
  import pdt_pkg::*;
#(
  parameter int LO_W = 4,
  parameter int HI_W = 4,
  localparam int CNT_W = LO_W + HI_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigIn,
  input  logic             loadBusy,
  input  logic             doubleMode,
  input  logic             ovlClr,
  input  logic [CNT_W-1:0] delayCount,
  input  logic [CNT_W-1:0] widthCount,
  output logic             trigOut,
  output logic             pulseOut,
  output logic             overlapFlag,
  output logic             busy
);
  pdtStrobe_t            strobe;
  logic [NUM_STAGES-1:0] coinc;

  pdt_control u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .trigIn      (trigIn),
    .loadBusy    (loadBusy),
    .doubleMode  (doubleMode),
    .ovlClr      (ovlClr),
    .coinc       (coinc),
    .strobe      (strobe),
    .trigOut     (trigOut),
    .pulseOut    (pulseOut),
    .overlapFlag (overlapFlag),
    .busy        (busy)
  );

  pdt_datapath #(.LO_W(LO_W), .HI_W(HI_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .delayCount (delayCount),
    .widthCount (widthCount),
    .strobe     (strobe),
    .coinc      (coinc)
  );
endmodule

// File: tb/pulse_delay_timer_bench.sv
module pulse_delay_timer_bench;
  localparam int LO_W  = 4;
  localparam int HI_W  = 4;
  localparam int CNT_W = LO_W + HI_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trigIn = 1'b0, loadBusy = 1'b0, doubleMode = 1'b0, ovlClr = 1'b0;
  logic [CNT_W-1:0] delayCount = '0, widthCount = '0;
  logic trigOut, pulseOut, overlapFlag, busy;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  pulse_delay_timer #(.LO_W(LO_W), .HI_W(HI_W)) u_pulse_delay_timer (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .loadBusy(loadBusy),
    .doubleMode(doubleMode), .ovlClr(ovlClr), .delayCount(delayCount),
    .widthCount(widthCount), .trigOut(trigOut), .pulseOut(pulseOut),
    .overlapFlag(overlapFlag), .busy(busy)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulseClear();
    @(negedge clk); ovlClr = 1'b1;
    @(negedge clk); ovlClr = 1'b0;
  endtask

  // Trigger once and compare whole traces against values derived from D and W.
  task automatic runCase(input string req, input int d, input int w, input bit dbl,
                         input int extraAt, input bit clrWithExtra, input int chgTo,
                         input int expOvl);
    int badTrig, badPulse, badBusy, firstBad, nCyc;
    bit exTrig, exPulse, exBusy;
    badTrig = 0; badPulse = 0; badBusy = 0; firstBad = -1;
    nCyc = d + w + 6;
    @(negedge clk);
    delayCount = CNT_W'(d); widthCount = CNT_W'(w); doubleMode = dbl;
    @(negedge clk); @(negedge clk);
    trigIn = 1'b1;
    @(negedge clk);
    for (int k = 0; k < nCyc; k++) begin
      trigIn = 1'b0; ovlClr = 1'b0;
      exTrig  = (k == 0);
      if (dbl) exPulse = (k <= w) || (d > w && k >= d + 1 && k <= d + 1 + w);
      else     exPulse = (k >= d + 1 && k <= d + 1 + w);
      exBusy = (k <= d) || exPulse;
      if (trigOut  != exTrig)  begin badTrig++;  if (firstBad < 0) firstBad = k; end
      if (pulseOut != exPulse) begin badPulse++; if (firstBad < 0) firstBad = k; end
      if (busy     != exBusy)  begin badBusy++;  if (firstBad < 0) firstBad = k; end
      if (k == extraAt) begin trigIn = 1'b1; ovlClr = clrWithExtra; end
      if (k == 2 && chgTo >= 0) delayCount = CNT_W'(chgTo);
      @(negedge clk);
    end
    if (firstBad >= 0) $display("  (%s D=%0d W=%0d first deviating cycle %0d)", req, d, w, firstBad);
    check(req, "trigOut trace mismatches", badTrig, 0);
    check(req, "pulseOut trace mismatches", badPulse, 0);
    check(req, "busy trace mismatches", badBusy, 0);
    check(req, "overlapFlag after run", int'(overlapFlag), expOvl);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1", "trigOut in reset", int'(trigOut), 0);
    check("R1", "pulseOut in reset", int'(pulseOut), 0);
    check("R1", "overlapFlag in reset", int'(overlapFlag), 0);
    check("R1", "busy in reset", int'(busy), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "busy after reset", int'(busy), 0);
  endtask

  task automatic testLoadLock();
    int seen;
    seen = 0;
    delayCount = CNT_W'(3); widthCount = CNT_W'(2); doubleMode = 1'b1;
    @(negedge clk); loadBusy = 1'b1;
    @(negedge clk); trigIn = 1'b1;
    @(negedge clk); trigIn = 1'b0;
    for (int k = 0; k < 20; k++) begin
      if (trigOut || pulseOut || busy) seen++;
      @(negedge clk);
    end
    loadBusy = 1'b0;
    check("R6", "activity cycles during loadBusy", seen, 0);
    check("R6", "overlapFlag after refused trigger", int'(overlapFlag), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    testReset();
    runCase("R3", 20, 5, 1'b0, -1, 1'b0, -1, 0);   // crosses low/high borrow
    runCase("R4", 16, 3, 1'b0, -1, 1'b0, -1, 0);   // low section starts at zero
    runCase("R5", 0, 0, 1'b0, -1, 1'b0, -1, 0);    // zero counts
    runCase("R2", 2, 7, 1'b0, -1, 1'b0, -1, 0);
    runCase("R7", 10, 2, 1'b0, 4, 1'b0, -1, 1);    // early trigger ignored, flagged
    pulseClear();
    check("R8", "overlapFlag after lone clear", int'(overlapFlag), 0);
    runCase("R8", 10, 2, 1'b0, 3, 1'b1, -1, 1);    // set and clear same cycle
    pulseClear();
    check("R8", "overlapFlag after second clear", int'(overlapFlag), 0);
    runCase("R9", 6, 2, 1'b1, -1, 1'b0, -1, 0);    // two pulses
    runCase("R9", 2, 4, 1'b1, -1, 1'b0, -1, 0);    // second start ignored
    runCase("R10", 8, 1, 1'b0, -1, 1'b0, 3, 0);    // mid-run change not used
    runCase("R10", 3, 1, 1'b0, -1, 1'b0, -1, 0);   // new count used next run
    testLoadLock();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule